// File: doc/BRIEF.md
# Link Transmit Character Arbiter with Credit Tracking

This block picks the character type a serial link transmitter sends in each character slot. It also tracks how many data characters the far end has allowed. The link state machine drives a slot strobe, a send enable, a run-phase flag and a transmitter reset. The local receiver raises requests to send a flow-control token and reports each flow-control token that arrives from the far end. A time-stamp source raises requests to send a time code. The host offers data characters through a valid/ready handshake.

The arbiter serves a time code first, then a flow-control token, then a host data character. If none of these can go, it sends a filler NULL so the link keeps toggling. Data characters draw on a credit count. Each token that arrives from the far end refills that count by eight. Each data character sent spends one.

Outside the run phase, only fillers and flow-control tokens may leave the block, which lets the link come up while the far end still has no credit to give. The chosen type appears, registered, one clock after the slot strobe. The encoder that follows turns it into line bits.

Top module: `link_tx_arbiter`

## Requirements
- R1: Each slot accepted while enabled yields exactly one character on `char_sel` with `char_valid` high, one clock after `slot`. The encoding is 0 NULL, 1 flow token, 2 data, 3 time code. A pending time code beats a pending flow token, which beats an eligible data character. No character appears without a slot.
- R2: If no time code, flow token or eligible data character is available at a slot, a NULL (code 0) is sent.
- R3: `credit` never exceeds 56. A token received while `credit` is above 48 leaves `credit` unchanged by that token and sets `credit_err`, which stays set until transmitter reset.
- R4: Each `fct_rcvd` pulse that does not overflow adds 8 to `credit`, visible one clock later.
- R5: `nchar_ready` is high only during a slot in the run phase, with `credit` non-zero and no time code or flow token pending. Each accepted data character (`nchar_valid` and `nchar_ready`) lowers `credit` by 1 on the next clock.
- R6: While `run_mode` is low, slots yield only NULL or flow token. A time code request made then stays pending and is sent at the first slot after `run_mode` rises.
- R7: `tx_rst` clears the credit, the overflow flag and both pending requests, and suppresses the character of that cycle. Requests presented in the same cycle are dropped.
- R8: While `send_en` is low, slots produce no character, and pending requests are held for later slots.
- R9: A token received in the same cycle that a data character is accepted changes `credit` by +7.
- R10: After `rst_n` is released, `credit` is 0, `credit_err` is 0 and `char_valid` is 0.
- R11: A request pulse arriving in the same cycle its pending copy is sent stays pending and is sent at a later slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_rst | input | 1 | Transmitter reset from the link state machine, active high |
| send_en | input | 1 | Transmitter allowed to send characters |
| run_mode | input | 1 | Link is in its run phase; data and time codes allowed |
| slot | input | 1 | Character slot strobe, one cycle per slot |
| tc_req | input | 1 | Pulse: a time code is waiting |
| fct_req | input | 1 | Pulse: local receiver asks for a flow token to be sent |
| fct_rcvd | input | 1 | Pulse: a flow token arrived from the far end |
| nchar_valid | input | 1 | Host offers a data character |
| nchar_ready | output | 1 | Data character taken in this cycle |
| char_valid | output | 1 | `char_sel` holds a new character choice |
| char_sel | output | 2 | Chosen character type (0 NULL, 1 flow token, 2 data, 3 time code) |
| credit | output | 6 | Data characters the far end currently allows |
| credit_err | output | 1 | Sticky credit overflow flag |

## Verification
The two functions that can fall in the same cycle are the credit refill from an arriving flow token and the credit spend from an accepted data character. The bench provokes this by pulsing `fct_rcvd` in the very slot where a data character is handed over. It then expects the credit to rise by exactly seven and a data character to appear in the scoreboard. A second collision, a fresh request arriving as its pending copy is granted, is judged by whether a second flow token shows up at the next slot.

// File: rtl/link_tx_pkg.sv
// Shared types and constants for the link transmit arbiter.
package link_tx_pkg;

    // Character type chosen for a slot; the encoder downstream decodes these values.
    typedef enum logic [1:0] {
        CH_NULL = 2'd0,
        CH_FCT  = 2'd1,
        CH_DATA = 2'd2,
        CH_TIME = 2'd3
    } char_kind_e;

    localparam int CREDIT_MAX_DEF  = 56;
    localparam int CREDIT_STEP_DEF = 8;

    // Indices into the pending-request vector.
    localparam int REQ_FCT  = 0;
    localparam int REQ_TIME = 1;
    localparam int REQ_NUM  = 2;

endpackage

// File: rtl/link_tx_pending.sv
// Single pending-request latch.
// Assumes: set and clr are single-cycle pulses; a set in the cycle of a clear wins.
module link_tx_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic set,
    input  logic clr,
    output logic pend
);
    // Hold a request until it is granted; flush drops it.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            pend <= 1'b0;
        end else begin
            pend <= (pend & ~clr) | set;
        end
    end
endmodule

// File: rtl/link_tx_credit.sv
// Credit counter: refilled by STEP for each received flow token, spent by one per data character.
// Assumes: take is only raised while the count is non-zero.
module link_tx_credit #(
    parameter int MAX  = link_tx_pkg::CREDIT_MAX_DEF,
    parameter int STEP = link_tx_pkg::CREDIT_STEP_DEF,
    localparam int CW  = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          add,
    input  logic          take,
    output logic [CW-1:0] count,
    output logic          ovf_flag
);
    localparam int SW = CW + 1;

    logic [SW-1:0] sum_add;
    logic          ovf_now;
    logic [SW-1:0] next_cnt;

    // Work out the refill, the overflow test and the net next value.
    always_comb begin
        sum_add  = {1'b0, count} + SW'(STEP);
        ovf_now  = add && (sum_add > SW'(MAX));
        next_cnt = (add && !ovf_now) ? sum_add : {1'b0, count};
        if (take) begin
            next_cnt = next_cnt - SW'(1);
        end
    end

    // Register the count and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count    <= '0;
            ovf_flag <= 1'b0;
        end else begin
            count    <= next_cnt[CW-1:0];
            ovf_flag <= ovf_flag | ovf_now;
        end
    end
endmodule

// File: rtl/link_tx_prio.sv
// Strict priority pick: time code, flow token, data, then NULL filler.
// Assumes: run gates time codes and data; data also needs non-zero credit.
module link_tx_prio (
    input  logic       time_pend,
    input  logic       fct_pend,
    input  logic       data_valid,
    input  logic       run,
    input  logic       credit_nz,
    output logic [1:0] pick
);
    import link_tx_pkg::*;

    // Choose the highest eligible character type.
    always_comb begin
        if (run && time_pend) begin
            pick = CH_TIME;
        end else if (fct_pend) begin
            pick = CH_FCT;
        end else if (run && data_valid && credit_nz) begin
            pick = CH_DATA;
        end else begin
            pick = CH_NULL;
        end
    end
endmodule

// File: rtl/link_tx_arbiter.sv
// Top: per-slot character choice for a link transmitter, with credit tracking.
// Assumes: slot is a one-cycle strobe; requests and fct_rcvd are one-cycle pulses.
module link_tx_arbiter #(
    parameter int CREDIT_MAX  = link_tx_pkg::CREDIT_MAX_DEF,
    parameter int CREDIT_STEP = link_tx_pkg::CREDIT_STEP_DEF,
    localparam int CW         = $clog2(CREDIT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_rst,
    input  logic          send_en,
    input  logic          run_mode,
    input  logic          slot,
    input  logic          tc_req,
    input  logic          fct_req,
    input  logic          fct_rcvd,
    input  logic          nchar_valid,
    output logic          nchar_ready,
    output logic          char_valid,
    output logic [1:0]    char_sel,
    output logic [CW-1:0] credit,
    output logic          credit_err
);
    import link_tx_pkg::*;

    logic                grant;
    logic [1:0]          pick;
    logic [REQ_NUM-1:0]  req_set;
    logic [REQ_NUM-1:0]  req_clr;
    logic [REQ_NUM-1:0]  pend;
    logic                take;

    // Decide whether this cycle consumes a slot, and route set/clear to the latches.
    always_comb begin
        grant             = slot && send_en && !tx_rst;
        req_set           = '0;
        req_set[REQ_FCT]  = fct_req;
        req_set[REQ_TIME] = tc_req;
        req_clr           = '0;
        req_clr[REQ_FCT]  = grant && (pick == CH_FCT);
        req_clr[REQ_TIME] = grant && (pick == CH_TIME);
        nchar_ready       = grant && (pick == CH_DATA);
        take              = nchar_ready && nchar_valid;
    end

    genvar g;
    generate
        for (g = 0; g < REQ_NUM; g++) begin : g_pend
            link_tx_pending u_pend (
                .clk  (clk),
                .rst_n(rst_n),
                .flush(tx_rst),
                .set  (req_set[g]),
                .clr  (req_clr[g]),
                .pend (pend[g])
            );
        end
    endgenerate

    link_tx_prio u_prio (
        .time_pend (pend[REQ_TIME]),
        .fct_pend  (pend[REQ_FCT]),
        .data_valid(nchar_valid),
        .run       (run_mode),
        .credit_nz (credit != '0),
        .pick      (pick)
    );

    link_tx_credit #(
        .MAX (CREDIT_MAX),
        .STEP(CREDIT_STEP)
    ) u_credit (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (tx_rst),
        .add     (fct_rcvd),
        .take    (take),
        .count   (credit),
        .ovf_flag(credit_err)
    );

    // Register the chosen character type for the encoder.
    always_ff @(posedge clk) begin
        if (!rst_n || tx_rst) begin
            char_valid <= 1'b0;
            char_sel   <= CH_NULL;
        end else begin
            char_valid <= grant;
            if (grant) begin
                char_sel <= pick;
            end
        end
    end
endmodule

// File: rtl/link_tx_arbiter_chk.sv
// Property checker for link_tx_arbiter; watches its ports only.
module link_tx_arbiter_chk #(
    parameter int CREDIT_MAX  = 56,
    parameter int CREDIT_STEP = 8,
    localparam int CW         = $clog2(CREDIT_MAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_rst,
    input logic          send_en,
    input logic          run_mode,
    input logic          slot,
    input logic          fct_rcvd,
    input logic          nchar_valid,
    input logic          nchar_ready,
    input logic          char_valid,
    input logic [1:0]    char_sel,
    input logic [CW-1:0] credit,
    input logic          credit_err
);
    // R3: the credit stays within its limit.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        credit <= CW'(CREDIT_MAX));

    // R1: no character without a slot.
    p_slot_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !slot |=> !char_valid);

    // R5: data handed over only in run phase with credit.
    p_data_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nchar_ready |-> (slot && run_mode && credit != '0));

    // R5: an accepted data character spends one credit.
    p_spend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nchar_valid && nchar_ready && !fct_rcvd && !tx_rst) |=> credit == $past(credit) - CW'(1));

    // R4: a non-overflowing token adds one step.
    p_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fct_rcvd && !tx_rst && !(nchar_valid && nchar_ready) && credit <= CW'(CREDIT_MAX - CREDIT_STEP))
        |=> credit == $past(credit) + CW'(CREDIT_STEP));

    // R6: outside run phase only NULL or flow token.
    p_prerun_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && send_en && !tx_rst && !run_mode) |=> (char_valid && (char_sel == 2'd0 || char_sel == 2'd1)));

    // R7: transmitter reset clears state.
    p_txrst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst |=> (credit == '0 && !credit_err && !char_valid));

    // R8: disabled sender emits nothing.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && !send_en) |=> !char_valid);
endmodule

bind link_tx_arbiter link_tx_arbiter_chk #(
    .CREDIT_MAX (CREDIT_MAX),
    .CREDIT_STEP(CREDIT_STEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_rst     (tx_rst),
    .send_en    (send_en),
    .run_mode   (run_mode),
    .slot       (slot),
    .fct_rcvd   (fct_rcvd),
    .nchar_valid(nchar_valid),
    .nchar_ready(nchar_ready),
    .char_valid (char_valid),
    .char_sel   (char_sel),
    .credit     (credit),
    .credit_err (credit_err)
);

// File: tb/test_link_tx_arbiter.sv
module test_link_tx_arbiter;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int K_NULL = 0, K_FCT = 1, K_DATA = 2, K_TIME = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, tx_rst = 1'b0, send_en = 1'b0, run_mode = 1'b0, slot = 1'b0;
    logic       tc_req = 1'b0, fct_req = 1'b0, fct_rcvd = 1'b0, nchar_valid = 1'b0;
    logic       nchar_ready, char_valid, credit_err;
    logic [1:0] char_sel;
    logic [5:0] credit;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    link_tx_arbiter i_link_tx_arbiter (
        .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst), .send_en(send_en), .run_mode(run_mode),
        .slot(slot), .tc_req(tc_req), .fct_req(fct_req), .fct_rcvd(fct_rcvd),
        .nchar_valid(nchar_valid), .nchar_ready(nchar_ready), .char_valid(char_valid),
        .char_sel(char_sel), .credit(credit), .credit_err(credit_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pop one expected character per emitted character.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && char_valid) begin
                if (exp_q.size() == 0) begin
                    check("R1 unexpected char", int'(char_sel), -1);
                end else begin
                    check(tag_q.pop_front(), int'(char_sel), exp_q.pop_front());
                end
            end
        end
    end

    // Driver: one slot, with its expected character pushed first; called just after a negedge.
    task automatic do_slot(input int exp, input string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        slot = 1'b1;
        @(negedge clk);
        slot = 1'b0;
    endtask

    task automatic pulse_cycle();
        @(negedge clk);
        tc_req = 1'b0; fct_req = 1'b0; fct_rcvd = 1'b0; tx_rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 credit", int'(credit), 0);
        check("R10 char_valid", int'(char_valid), 0);
        check("R10 credit_err", int'(credit_err), 0);

        // R2: connecting phase, nothing pending -> NULL
        send_en = 1'b1;
        do_slot(K_NULL, "R2 idle null");
        // R6: flow token allowed before run
        fct_req = 1'b1; pulse_cycle();
        do_slot(K_FCT, "R6 fct before run");
        // R6: time code held until run
        tc_req = 1'b1; pulse_cycle();
        do_slot(K_NULL, "R6 time held");
        run_mode = 1'b1;
        do_slot(K_TIME, "R6 time after run");

        // R5: no credit -> data not taken
        nchar_valid = 1'b1;
        slot = 1'b1; #1;
        check("R5 ready without credit", int'(nchar_ready), 0);
        exp_q.push_back(K_NULL); tag_q.push_back("R5 null without credit");
        @(negedge clk); slot = 1'b0;

        // R4: refill
        fct_rcvd = 1'b1; pulse_cycle();
        check("R4 credit after token", int'(credit), 8);

        // R1: all three compete
        tc_req = 1'b1; fct_req = 1'b1; pulse_cycle();
        slot = 1'b1; #1;
        check("R5 ready while requests pending", int'(nchar_ready), 0);
        exp_q.push_back(K_TIME); tag_q.push_back("R1 time first");
        @(negedge clk); slot = 1'b0;
        do_slot(K_FCT, "R1 fct second");
        slot = 1'b1; #1;
        check("R5 ready with credit", int'(nchar_ready), 1);
        exp_q.push_back(K_DATA); tag_q.push_back("R1 data third");
        @(negedge clk); slot = 1'b0;
        check("R5 credit spent", int'(credit), 7);

        // R9: refill and spend in one cycle
        fct_rcvd = 1'b1;
        exp_q.push_back(K_DATA); tag_q.push_back("R9 data with refill");
        slot = 1'b1;
        @(negedge clk); slot = 1'b0; fct_rcvd = 1'b0;
        check("R9 net credit", int'(credit), 14);

        // R3: fill up to overflow
        nchar_valid = 1'b0;
        for (int i = 0; i < 5; i++) begin
            fct_rcvd = 1'b1; pulse_cycle();
        end
        check("R4 credit after five tokens", int'(credit), 54);
        check("R3 no error yet", int'(credit_err), 0);
        fct_rcvd = 1'b1; pulse_cycle();
        check("R3 credit unchanged on overflow", int'(credit), 54);
        check("R3 error set", int'(credit_err), 1);

        // R6: data not sent outside run even with credit
        run_mode = 1'b0; nchar_valid = 1'b1;
        do_slot(K_NULL, "R6 no data before run");
        nchar_valid = 1'b0; run_mode = 1'b1;

        // R11: new request in the grant cycle stays pending
        fct_req = 1'b1; pulse_cycle();
        fct_req = 1'b1;
        exp_q.push_back(K_FCT); tag_q.push_back("R11 first fct");
        slot = 1'b1;
        @(negedge clk); slot = 1'b0; fct_req = 1'b0;
        do_slot(K_FCT, "R11 second fct");
        do_slot(K_NULL, "R11 then null");

        // R8: disabled sender holds requests
        send_en = 1'b0;
        fct_req = 1'b1; pulse_cycle();
        slot = 1'b1;
        @(negedge clk); slot = 1'b0;
        check("R8 no char while disabled", int'(char_valid), 0);
        send_en = 1'b1;
        do_slot(K_FCT, "R8 held fct sent");

        // R7: transmitter reset clears and drops same-cycle requests
        tx_rst = 1'b1; fct_req = 1'b1; tc_req = 1'b1; pulse_cycle();
        check("R7 credit cleared", int'(credit), 0);
        check("R7 error cleared", int'(credit_err), 0);
        do_slot(K_NULL, "R7 requests dropped");

        repeat (3) @(negedge clk);
        check("R1 all expected chars seen", exp_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule